// File: doc/BRIEF.md
# Dual TAP Handoff Controller

This block is the first test access port a chip shows on its JTAG pins. It contains a full 16-state IEEE 1149.1 state machine. It also has a 4-bit instruction register and three data paths: a single-bit bypass stage, a 32-bit identification register, and a pass-through to an external boundary-scan chain. After power-up it is the only controller on the pins.

A debugger can give the pins to a secondary emulation TAP in one of two ways. The first is to scan the handoff opcode into the instruction register and pass through Update-IR. The second is to hold the active-low debug-event input low for two TCK rising edges while the state machine sits in Test-Logic-Reset. The handoff is one-way. While it lasts, TMS and TDI are forwarded to the secondary TAP and its serial output drives TDO. The local state machine is held in Test-Logic-Reset. The local TAP comes back only after a power-on reset or a low level on the test reset pin.

The boundary-scan cells and the internals of the secondary TAP sit outside the block. They reach it only through their serial output pins.

Top module: `jtag_dual_tap`

## Requirements
- R1: While `por_n` or `trst_n` is low, `sec_en` and `tdo_oe` are 0. After release, the active instruction is IDCODE (opcode 0x2), so a Shift-DR scan returns the 32-bit IDCODE parameter LSB first. Entering Test-Logic-Reset always reloads IDCODE.
- R2: In Capture-IR the instruction shift register loads 4'b0001. Shift-IR shifts TDI in at the MSB and presents the LSB on TDO.
- R3: Any opcode other than 0x0 and 0x2 selects the 1-bit bypass stage. Its first shifted-out bit is the 0 captured in Capture-DR, and each later bit is TDI from the previous shift cycle.
- R4: Opcode 0x0 selects the boundary chain. During Shift-DR, TDO carries `bsr_tdo`.
- R5: TDO is registered on the falling edge of TCK. `tdo_oe` is high only in Shift-DR or Shift-IR, unless the handoff is active.
- R6: Passing through Update-IR with 0x3 in the instruction shift register sets `sec_en` at the rising edge that leaves Update-IR.
- R7: `sec_en` sets after two consecutive rising edges that sample `dbg_evt_n` low while the state is Test-Logic-Reset. The count clears when `dbg_evt_n` is high or the state leaves Test-Logic-Reset, so a single-cycle pulse, or a low level outside Test-Logic-Reset, leaves `sec_en` at 0.
- R8: While `sec_en` is 1: `tdo` equals `sec_tdo`, `tdo_oe` is 1, `sec_tms` equals `tms`, `sec_tdi` equals `tdi`, and the local state machine stays in Test-Logic-Reset. While `sec_en` is 0, `sec_tms` is 1 and `sec_tdi` is 0.
- R9: Once set, `sec_en` stays set whatever the TMS, TDI or debug-event activity. It clears at once when `por_n` or `trst_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| trst_n | input | 1 | Active-low asynchronous test reset |
| por_n | input | 1 | Active-low power-on reset |
| dbg_evt_n | input | 1 | Active-low debug-event request |
| bsr_tdo | input | 1 | Serial output of the external boundary chain |
| sec_tdo | input | 1 | Serial output of the secondary TAP |
| tdo | output | 1 | Test data out |
| tdo_oe | output | 1 | Output enable for TDO |
| sec_en | output | 1 | Secondary TAP owns the port |
| sec_tms | output | 1 | TMS forwarded to the secondary TAP |
| sec_tdi | output | 1 | TDI forwarded to the secondary TAP |

## Verification
The bench sends a one-cycle debug-event pulse in Test-Logic-Reset and a long low level in Run-Test/Idle, and expects no handoff from either. A counter that did not clear, or did not check the state, would hand over the port early. It shows that TDO holds its value across a rising edge, so a design clocking TDO on the wrong edge would present each bit half a cycle early. After a handoff it scans a full instruction and data sequence and checks that TDO still follows the secondary TAP. A local state machine that was not held would grab TDO back. It then pulls the test reset low and reads the IDCODE to confirm the local TAP has returned. A design whose handoff was not sticky, or whose reset did not clear it, fails there.

// File: rtl/jth_pkg.sv
package jth_pkg;
   typedef enum logic [3:0] {
      ST_EX2_DR = 4'h0, ST_EX1_DR = 4'h1, ST_SH_DR  = 4'h2, ST_PAU_DR = 4'h3,
      ST_SEL_IR = 4'h4, ST_UPD_DR = 4'h5, ST_CAP_DR = 4'h6, ST_SEL_DR = 4'h7,
      ST_EX2_IR = 4'h8, ST_EX1_IR = 4'h9, ST_SH_IR  = 4'hA, ST_PAU_IR = 4'hB,
      ST_RTI    = 4'hC, ST_UPD_IR = 4'hD, ST_CAP_IR = 4'hE, ST_TLR    = 4'hF
   } tap_state_e;

   typedef enum logic [1:0] {
      DR_BYPASS = 2'd0,
      DR_IDCODE = 2'd1,
      DR_BSCAN  = 2'd2
   } dr_sel_e;
endpackage

// File: rtl/jth_fsm.sv
module jth_fsm
   import jth_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       hold,
   input  logic       tms,
   output tap_state_e state
);
   tap_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
         ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
         default:   nxt = ST_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)    state <= ST_TLR;
      else if (hold) state <= ST_TLR;
      else           state <= nxt;
   end

   // R8
   hold_tlr_chk: assert property (@(posedge tck) disable iff (!rst_n)
      hold |=> (state == ST_TLR));
endmodule

// File: rtl/jth_ir.sv
module jth_ir
   import jth_pkg::*;
#(
   parameter int          IR_W      = 4,
   parameter logic [IR_W-1:0] OP_IDCODE = 4'h2,
   parameter logic [IR_W-1:0] CAPT      = 4'b0001
) (
   input  logic            tck,
   input  logic            rst_n,
   input  tap_state_e      state,
   input  logic            tdi,
   output logic [IR_W-1:0] ir_q,
   output logic [IR_W-1:0] ir_sr,
   output logic            so
);
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         ir_sr <= CAPT;
      end else if (state == ST_CAP_IR) begin
         ir_sr <= CAPT;
      end else if (state == ST_SH_IR) begin
         ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)                  ir_q <= OP_IDCODE;
      else if (state == ST_TLR)    ir_q <= OP_IDCODE;
      else if (state == ST_UPD_IR) ir_q <= ir_sr;
   end

   assign so = ir_sr[0];

   // R1
   tlr_idcode_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (state == ST_TLR) |=> (ir_q == OP_IDCODE));
endmodule

// File: rtl/jth_dr.sv
module jth_dr
   import jth_pkg::*;
#(
   parameter int          ID_W   = 32,
   parameter logic [ID_W-1:0] IDCODE = 32'h1A2B_C0DF
) (
   input  logic       tck,
   input  logic       rst_n,
   input  tap_state_e state,
   input  dr_sel_e    sel,
   input  logic       tdi,
   input  logic       bsr_tdo,
   output logic       so
);
   logic            byp_q;
   logic [ID_W-1:0] id_sr;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         byp_q <= 1'b0;
      end else if (sel == DR_BYPASS) begin
         if (state == ST_CAP_DR)     byp_q <= 1'b0;
         else if (state == ST_SH_DR) byp_q <= tdi;
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         id_sr <= IDCODE;
      end else if (sel == DR_IDCODE) begin
         if (state == ST_CAP_DR)     id_sr <= IDCODE;
         else if (state == ST_SH_DR) id_sr <= {tdi, id_sr[ID_W-1:1]};
      end
   end

   always_comb begin
      unique case (sel)
         DR_IDCODE: so = id_sr[0];
         DR_BSCAN:  so = bsr_tdo;
         default:   so = byp_q;
      endcase
   end

   // R3
   byp_cap_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (state == ST_CAP_DR && sel == DR_BYPASS) |=> (byp_q == 1'b0));
endmodule

// File: rtl/jth_handoff.sv
module jth_handoff
   import jth_pkg::*;
#(
   parameter int          IR_W       = 4,
   parameter logic [IR_W-1:0] OP_HANDOFF = 4'h3,
   parameter int          DBG_CYCLES = 2
) (
   input  logic            tck,
   input  logic            rst_n,
   input  logic            trst_n,
   input  tap_state_e      state,
   input  logic [IR_W-1:0] ir_sr,
   input  logic            dbg_evt_n,
   output logic            sec_en
);
   localparam int CNT_W = $clog2(DBG_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DBG_CYCLES - 1);

   logic [CNT_W-1:0] cnt;
   logic             arm, dbg_hit, ir_hit;

   assign arm    = trst_n && !sec_en && (state == ST_TLR) && !dbg_evt_n;
   assign ir_hit = (state == ST_UPD_IR) && (ir_sr == OP_HANDOFF);

   generate
      if (DBG_CYCLES == 1) begin : g_single
         assign dbg_hit = arm;
      end else begin : g_count
         assign dbg_hit = arm && (cnt == LAST);
      end
   endgenerate

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!arm)    cnt <= '0;
      else if (!dbg_hit) cnt <= cnt + 1'b1;
      else              cnt <= '0;
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)                 sec_en <= 1'b0;
      else if (ir_hit || dbg_hit) sec_en <= 1'b1;
   end

   // R9
   sticky_chk: assert property (@(posedge tck) disable iff (!rst_n)
      sec_en |=> sec_en);
   // R6
   ir_handoff_chk: assert property (@(posedge tck) disable iff (!rst_n)
      ((state == ST_UPD_IR) && (ir_sr == OP_HANDOFF)) |=> sec_en);
   // R7
   cnt_clear_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (dbg_evt_n || (state != ST_TLR)) |=> (cnt == '0));
endmodule

// File: rtl/jtag_dual_tap.sv
module jtag_dual_tap
   import jth_pkg::*;
#(
   parameter int          IR_W       = 4,
   parameter int          ID_W       = 32,
   parameter logic [ID_W-1:0] IDCODE     = 32'h1A2B_C0DF,
   parameter logic [IR_W-1:0] OP_BSCAN   = 4'h0,
   parameter logic [IR_W-1:0] OP_IDCODE  = 4'h2,
   parameter logic [IR_W-1:0] OP_HANDOFF = 4'h3,
   parameter logic [IR_W-1:0] IR_CAPT    = 4'b0001,
   parameter int          DBG_CYCLES = 2
) (
   input  logic tck,
   input  logic tms,
   input  logic tdi,
   input  logic trst_n,
   input  logic por_n,
   input  logic dbg_evt_n,
   input  logic bsr_tdo,
   input  logic sec_tdo,
   output logic tdo,
   output logic tdo_oe,
   output logic sec_en,
   output logic sec_tms,
   output logic sec_tdi
);
   generate
      if (IDCODE[0] != 1'b1) begin : g_bad_id
         $error("IDCODE bit 0 must be 1");
      end
      if (IR_W < 2) begin : g_bad_irw
         $error("IR_W must be at least 2");
      end
      if (OP_HANDOFF == OP_IDCODE || OP_HANDOFF == OP_BSCAN || OP_IDCODE == OP_BSCAN) begin : g_bad_op
         $error("opcodes must be distinct");
      end
      if (DBG_CYCLES < 1) begin : g_bad_dbg
         $error("DBG_CYCLES must be at least 1");
      end
   endgenerate

   logic            rst_n;
   tap_state_e      state;
   logic [IR_W-1:0] ir_q, ir_sr;
   logic            ir_so, dr_so, ser_bit;
   dr_sel_e         sel;
   logic            tdo_q, oe_q;

   assign rst_n = por_n & trst_n;

   jth_fsm i_fsm (
      .tck(tck), .rst_n(rst_n), .hold(sec_en), .tms(tms), .state(state)
   );

   jth_ir #(.IR_W(IR_W), .OP_IDCODE(OP_IDCODE), .CAPT(IR_CAPT)) i_ir (
      .tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
      .ir_q(ir_q), .ir_sr(ir_sr), .so(ir_so)
   );

   always_comb begin
      if (ir_q == OP_IDCODE)     sel = DR_IDCODE;
      else if (ir_q == OP_BSCAN) sel = DR_BSCAN;
      else                       sel = DR_BYPASS;
   end

   jth_dr #(.ID_W(ID_W), .IDCODE(IDCODE)) i_dr (
      .tck(tck), .rst_n(rst_n), .state(state), .sel(sel),
      .tdi(tdi), .bsr_tdo(bsr_tdo), .so(dr_so)
   );

   jth_handoff #(.IR_W(IR_W), .OP_HANDOFF(OP_HANDOFF), .DBG_CYCLES(DBG_CYCLES)) i_hand (
      .tck(tck), .rst_n(rst_n), .trst_n(trst_n), .state(state),
      .ir_sr(ir_sr), .dbg_evt_n(dbg_evt_n), .sec_en(sec_en)
   );

   assign ser_bit = (state == ST_SH_IR) ? ir_so : dr_so;

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n) begin
         tdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         tdo_q <= ser_bit;
         oe_q  <= (state == ST_SH_DR) || (state == ST_SH_IR);
      end
   end

   assign tdo     = sec_en ? sec_tdo : tdo_q;
   assign tdo_oe  = sec_en | oe_q;
   assign sec_tms = sec_en ? tms : 1'b1;
   assign sec_tdi = sec_en & tdi;

   // R5
   oe_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (!sec_en && tdo_oe) |-> ((state == ST_SH_DR) || (state == ST_SH_IR)));
endmodule

// File: tb/test_jtag_dual_tap.sv
`timescale 1ns/1ps
module test_jtag_dual_tap;
   localparam logic [31:0] ID = 32'h1A2B_C0DF;
   localparam int WD_CYC = 200000;

   logic tck = 1'b0;
   logic tms = 1'b1, tdi = 1'b0, trst_n = 1'b0, por_n = 1'b0;
   logic dbg_evt_n = 1'b1, bsr_tdo = 1'b0, sec_tdo = 1'b0;
   logic tdo, tdo_oe, sec_en, sec_tms, sec_tdi;
   int checks = 0, fails = 0;
   bit done = 0;

   always #2.5 tck = ~tck;

   jtag_dual_tap #(.IDCODE(ID)) i_jtag_dual_tap (
      .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .por_n(por_n),
      .dbg_evt_n(dbg_evt_n), .bsr_tdo(bsr_tdo), .sec_tdo(sec_tdo),
      .tdo(tdo), .tdo_oe(tdo_oe), .sec_en(sec_en),
      .sec_tms(sec_tms), .sec_tdi(sec_tdi)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // inputs are set just after a falling edge; returns just after the next falling edge
   task automatic step(input logic m, input logic d);
      tms = m; tdi = d;
      @(posedge tck);
      @(negedge tck); #1;
   endtask

   task automatic do_reset(input bit use_por);
      if (use_por) por_n = 1'b0; else trst_n = 1'b0;
      #1;
      chk("R1 sec_en in reset", sec_en, 0);
      chk("R1 tdo_oe in reset", tdo_oe, 0);
      step(1, 0); step(1, 0);
      por_n = 1'b1; trst_n = 1'b1;
      step(1, 0);
   endtask

   task automatic load_ir(input logic [3:0] op, output logic [3:0] cap);
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 4; i++) begin
         cap[i] = tdo;
         step(i == 3, op[i]);
      end
      step(1, 0);
      step(0, 0);
   endtask

   task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
      dout = '0;
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < n; i++) begin
         dout[i] = tdo;
         step(i == n - 1, din[i]);
      end
      step(1, 0);
      step(0, 0);
   endtask

   task automatic t_reset_idcode();
      logic [31:0] d;
      do_reset(1);
      step(0, 0);
      chk("R5 oe low in idle", tdo_oe, 0);
      chk("R8 idle sec_tms", sec_tms, 1);
      chk("R8 idle sec_tdi", sec_tdi, 0);
      shift_dr(32, 32'h0, d);
      chk("R1 idcode after reset", d, ID);
   endtask

   task automatic t_ir_capture();
      logic [3:0] c;
      logic [31:0] d;
      load_ir(4'h2, c);
      chk("R2 capture pattern", {28'h0, c}, 32'h1);
      shift_dr(32, 32'h0, d);
      chk("R1 idcode via explicit opcode", d, ID);
   endtask

   task automatic t_bypass();
      logic [3:0] c;
      logic [31:0] d;
      load_ir(4'hF, c);
      shift_dr(8, 32'h0000_00B5, d);
      chk("R3 bypass delay 0xF", d[7:0], {8'hB5 << 1});
      load_ir(4'h7, c);
      shift_dr(6, 32'h0000_002C, d);
      chk("R3 bypass delay 0x7", d[5:0], 6'h18);
   endtask

   task automatic t_bscan();
      logic [3:0] c;
      load_ir(4'h0, c);
      bsr_tdo = 1'b1;
      step(1, 0); step(0, 0); step(0, 0);
      chk("R4 bscan bit 1", tdo, 1);
      chk("R5 oe in shift-dr", tdo_oe, 1);
      bsr_tdo = 1'b0;
      @(posedge tck); #1;
      chk("R5 tdo holds across rising edge", tdo, 1);
      @(negedge tck); #1;
      chk("R4 bscan bit 0", tdo, 0);
      step(1, 0); step(1, 0); step(0, 0);
      chk("R5 oe low after shift", tdo_oe, 0);
   endtask

   task automatic t_dbg_event();
      logic [3:0] c;
      logic [31:0] d;
      do_reset(0);
      dbg_evt_n = 1'b0; step(1, 0);
      dbg_evt_n = 1'b1; step(1, 0);
      dbg_evt_n = 1'b0; step(1, 0);
      dbg_evt_n = 1'b1; step(1, 0);
      chk("R7 single pulses ignored", sec_en, 0);
      step(0, 0);
      dbg_evt_n = 1'b0; step(0, 0); step(0, 0); step(0, 0);
      dbg_evt_n = 1'b1;
      chk("R7 low outside TLR ignored", sec_en, 0);
      step(1, 0); step(1, 0); step(1, 0);
      dbg_evt_n = 1'b0; step(1, 0);
      chk("R7 one cycle not enough", sec_en, 0);
      step(1, 0);
      dbg_evt_n = 1'b1;
      chk("R7 handoff after two cycles", sec_en, 1);
      // routing and hold
      sec_tdo = 1'b1; #1;
      chk("R8 tdo follows sec_tdo 1", tdo, 1);
      sec_tdo = 1'b0; #1;
      chk("R8 tdo follows sec_tdo 0", tdo, 0);
      chk("R8 oe during handoff", tdo_oe, 1);
      tms = 1'b0; tdi = 1'b1; #1;
      chk("R8 sec_tms forward", sec_tms, 0);
      chk("R8 sec_tdi forward", sec_tdi, 1);
      load_ir(4'h2, c);
      sec_tdo = 1'b1;
      shift_dr(8, 32'h0, d);
      chk("R8 tdo stays on secondary", d[7:0], 8'hFF);
      dbg_evt_n = 1'b0; step(1, 0); step(1, 0); dbg_evt_n = 1'b1;
      chk("R9 sticky", sec_en, 1);
      sec_tdo = 1'b0;
      trst_n = 1'b0; #1;
      chk("R9 trst clears", sec_en, 0);
      step(1, 0);
      trst_n = 1'b1;
      step(1, 0); step(0, 0);
      shift_dr(32, 32'h0, d);
      chk("R9 local tap back", d, ID);
   endtask

   task automatic t_ir_handoff();
      logic [3:0] c;
      load_ir(4'h3, c);
      chk("R6 handoff on update-ir", sec_en, 1);
      step(1, 0); step(0, 1);
      chk("R9 sticky after ir handoff", sec_en, 1);
      por_n = 1'b0; #1;
      chk("R9 por clears", sec_en, 0);
      step(1, 0);
      por_n = 1'b1;
      step(1, 0);
   endtask

   initial begin
      @(negedge tck); #1;
      t_reset_idcode();
      t_ir_capture();
      t_bypass();
      t_bscan();
      t_dbg_event();
      t_ir_handoff();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (WD_CYC) @(posedge tck);
      if (!done) begin
         fails++;
         $display("FAIL watchdog got=timeout exp=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule